// File: doc/BRIEF.md
# Warp Load Coalescer

This block takes a single 32-lane memory request. Each lane supplies a valid flag and the byte address of a 4-byte element. The block reduces the active lanes to a short list of aligned off-chip transactions, and each transaction is either a 32-byte sector or a whole 128-byte line. It emits these transactions one at a time on a valid/ready channel. Each transaction carries its aligned base address, a size flag and the mask of lanes it serves. Stores pass through the same path as loads. Returning the data and putting it back together per lane is the job of other logic.

The block visits lines in ascending address order. For each line it counts how many of its four sectors are touched. A line with enough touched sectors is fetched whole in one transaction. In any other line, each touched sector gets its own 32-byte transaction. When the request completes, two counters show the useful bytes and the bytes moved. Their ratio is the efficiency of the access pattern.

Top module: `coalescer_top`

## Requirements
- R1: After reset, reqReady is 1, txnValid and done are 0, and both byte counters read 0.
- R2: Every transaction address is aligned to its own size. txnWide=1 means a 128-byte line (address bits 6:0 zero). txnWide=0 means a 32-byte sector (address bits 4:0 zero).
- R3: A 128-byte line in which at least WIDE_MIN_SECTORS (default 3) of its four 32-byte sectors hold active-lane addresses is issued as one wide transaction. Otherwise each touched sector of that line is issued as its own 32-byte transaction.
- R4: Thirty-two valid lanes at consecutive 4-byte addresses starting on a 128-byte boundary produce exactly one wide transaction with mask 32'hFFFFFFFF, and both counters read 128.
- R5: Within one request, the transactions are issued in strictly ascending address order.
- R6: Bit i of txnMask is set when lane i is valid and its address lies inside that transaction. The masks of one request do not overlap, and together they equal laneValid.
- R7: When done is high, bytesRequested equals 4 times the number of valid lanes, and bytesTransferred equals the sum of 128 for each wide transaction and 32 for each narrow one.
- R8: A request with laneValid all zero issues no transaction, and done pulses in the cycle after it is accepted.
- R9: While txnValid is high and txnReady is low, txnValid, txnAddr, txnWide and txnMask hold their values into the next cycle.
- R10: done pulses for one cycle, in the cycle after the last transaction handshake. reqReady is high again in the cycle after done. txnValid is never high while reqReady or done is high.
- R11: The addresses of invalid lanes have no effect on the transactions or on the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present on laneValid/laneAddr |
| reqReady | output | 1 | Block is idle and accepts a request |
| laneValid | input | 32 | Per-lane active flag |
| laneAddr | input | 1024 | Lane i byte address in bits [32*i+31:32*i] |
| txnValid | output | 1 | A transaction is offered |
| txnReady | input | 1 | Downstream takes the offered transaction |
| txnAddr | output | 32 | Aligned base address of the transaction |
| txnWide | output | 1 | 1: 128-byte line, 0: 32-byte sector |
| txnMask | output | 32 | Lanes served by the transaction |
| done | output | 1 | One-cycle pulse when the request is finished |
| bytesRequested | output | 13 | Useful bytes of the last request |
| bytesTransferred | output | 13 | Bytes moved for the last request |

## Verification
The accept edge is the edge where reqValid and reqReady are both high. The first transaction is offered in the cycle after that edge. Each later transaction is offered in the cycle after the previous handshake edge. done and the final counter values appear in the cycle after the last handshake, or in the cycle after the accept edge for an empty request. The bench drives inputs on the falling edge and reads the combinational outputs at that same falling edge. At each falling edge it compares the offered transaction against a list built by a bench model of the line and sector rules. It records a handshake only when it has driven txnReady high for the coming rising edge. It counts cycles from the accept edge, so the check that done comes exactly one cycle after the last handshake is exact.

// File: rtl/coalescer_pkg.sv
package coalescer_pkg;
  typedef struct packed {
    logic load;
    logic issue;
  } ctrlStrobes_t;
endpackage

// File: rtl/coalescer_datapath.sv
module coalescer_datapath
  import coalescer_pkg::*;
#(
  parameter int LANES            = 32,
  parameter int AW               = 32,
  parameter int ELEM_BYTES       = 4,
  parameter int LINE_BYTES       = 128,
  parameter int SECTOR_BYTES     = 32,
  parameter int WIDE_MIN_SECTORS = 3,
  localparam int SEC_PER_LINE    = LINE_BYTES / SECTOR_BYTES,
  localparam int LINE_SH         = $clog2(LINE_BYTES),
  localparam int SEC_SH          = $clog2(SECTOR_BYTES),
  localparam int CNT_W           = $clog2(LANES * LINE_BYTES + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [LANES-1:0]    laneValid,
  input  logic [LANES*AW-1:0] laneAddr,
  output logic                pendEmpty,
  output logic [AW-1:0]       txnAddr,
  output logic                txnWide,
  output logic [LANES-1:0]    txnMask,
  output logic [CNT_W-1:0]    bytesRequested,
  output logic [CNT_W-1:0]    bytesTransferred
);
  localparam logic [AW-1:0] LINE_KEEP = ~AW'(LINE_BYTES - 1);
  localparam logic [AW-1:0] SEC_KEEP  = ~AW'(SECTOR_BYTES - 1);

  logic [LANES-1:0]        pending;
  logic [AW-1:0]           addrQ [LANES];
  logic [AW-1:0]           headAddr;
  logic                    headFound;
  logic [LANES-1:0]        lineMask, secMask;
  logic [SEC_PER_LINE-1:0] touched;

  // lowest pending address selects the line served next
  always_comb begin
    headAddr  = '0;
    headFound = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (pending[i] && (!headFound || addrQ[i] < headAddr)) begin
        headAddr  = addrQ[i];
        headFound = 1'b1;
      end
    end
  end

  always_comb begin
    touched = '0;
    for (int i = 0; i < LANES; i++) begin
      lineMask[i] = pending[i] && ((addrQ[i] & LINE_KEEP) == (headAddr & LINE_KEEP));
      secMask[i]  = pending[i] && ((addrQ[i] & SEC_KEEP) == (headAddr & SEC_KEEP));
      if (lineMask[i]) touched[addrQ[i][LINE_SH-1:SEC_SH]] = 1'b1;
    end
  end

  assign txnWide   = $countones(touched) >= WIDE_MIN_SECTORS;
  assign txnAddr   = txnWide ? (headAddr & LINE_KEEP) : (headAddr & SEC_KEEP);
  assign txnMask   = txnWide ? lineMask : secMask;
  assign pendEmpty = ~|pending;

  always_ff @(posedge clk) begin
    if (strobes.load) begin
      for (int i = 0; i < LANES; i++) addrQ[i] <= laneAddr[i*AW +: AW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending          <= '0;
      bytesRequested   <= '0;
      bytesTransferred <= '0;
    end else if (strobes.load) begin
      pending          <= laneValid;
      bytesRequested   <= CNT_W'($countones(laneValid) * ELEM_BYTES);
      bytesTransferred <= '0;
    end else if (strobes.issue) begin
      pending          <= pending & ~txnMask;
      bytesTransferred <= bytesTransferred + CNT_W'(txnWide ? LINE_BYTES : SECTOR_BYTES);
    end
  end
endmodule

// File: rtl/coalescer_ctrl.sv
module coalescer_ctrl
  import coalescer_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output logic         reqReady,
  input  logic         pendEmpty,
  output logic         txnValid,
  input  logic         txnReady,
  output logic         done,
  output ctrlStrobes_t strobes
);
  typedef enum logic {IDLE, BUSY} state_t;
  state_t state;

  assign reqReady      = (state == IDLE);
  assign txnValid      = (state == BUSY) && !pendEmpty;
  assign done          = (state == BUSY) && pendEmpty;
  assign strobes.load  = reqValid && reqReady;
  assign strobes.issue = txnValid && txnReady;

  always_ff @(posedge clk) begin
    if (!rstN)             state <= IDLE;
    else if (strobes.load) state <= BUSY;
    else if (done)         state <= IDLE;
  end
endmodule

// File: rtl/coalescer_top.sv
module coalescer_top
  import coalescer_pkg::*;
#(
  parameter int LANES            = 32,
  parameter int AW               = 32,
  parameter int ELEM_BYTES       = 4,
  parameter int LINE_BYTES       = 128,
  parameter int SECTOR_BYTES     = 32,
  parameter int WIDE_MIN_SECTORS = 3,
  localparam int CNT_W           = $clog2(LANES * LINE_BYTES + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [LANES-1:0]    laneValid,
  input  logic [LANES*AW-1:0] laneAddr,
  output logic                txnValid,
  input  logic                txnReady,
  output logic [AW-1:0]       txnAddr,
  output logic                txnWide,
  output logic [LANES-1:0]    txnMask,
  output logic                done,
  output logic [CNT_W-1:0]    bytesRequested,
  output logic [CNT_W-1:0]    bytesTransferred
);
  ctrlStrobes_t strobes;
  logic         pendEmpty;

  coalescer_ctrl ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .pendEmpty(pendEmpty), .txnValid(txnValid), .txnReady(txnReady),
    .done(done), .strobes(strobes)
  );

  coalescer_datapath #(
    .LANES(LANES), .AW(AW), .ELEM_BYTES(ELEM_BYTES), .LINE_BYTES(LINE_BYTES),
    .SECTOR_BYTES(SECTOR_BYTES), .WIDE_MIN_SECTORS(WIDE_MIN_SECTORS)
  ) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .laneValid(laneValid),
    .laneAddr(laneAddr), .pendEmpty(pendEmpty), .txnAddr(txnAddr),
    .txnWide(txnWide), .txnMask(txnMask), .bytesRequested(bytesRequested),
    .bytesTransferred(bytesTransferred)
  );
endmodule

// File: rtl/coalescer_chk.sv
module coalescer_chk #(
  parameter int LANES        = 32,
  parameter int AW           = 32,
  parameter int LINE_BYTES   = 128,
  parameter int SECTOR_BYTES = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             txnValid,
  input logic             txnReady,
  input logic [AW-1:0]    txnAddr,
  input logic             txnWide,
  input logic [LANES-1:0] txnMask,
  input logic             done
);
  logic [AW-1:0]    lastAddr;
  logic             haveLast;
  logic [LANES-1:0] served;

  always_ff @(posedge clk) begin
    if (!rstN || (reqValid && reqReady)) begin
      haveLast <= 1'b0;
      lastAddr <= '0;
      served   <= '0;
    end else if (txnValid && txnReady) begin
      haveLast <= 1'b1;
      lastAddr <= txnAddr;
      served   <= served | txnMask;
    end
  end

  // R2
  addr_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> ((txnAddr & AW'(SECTOR_BYTES - 1)) == '0) &&
                 (!txnWide || ((txnAddr & AW'(LINE_BYTES - 1)) == '0)));
  // R5
  ascending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txnValid && haveLast) |-> (txnAddr > lastAddr));
  // R6
  mask_disjoint_chk: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> (txnMask != '0) && ((txnMask & served) == '0));
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txnValid && !txnReady) |=> txnValid && $stable(txnAddr) && $stable(txnWide) && $stable(txnMask));
  // R10
  done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(txnValid && (done || reqReady)));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> reqReady && !done);
endmodule

bind coalescer_top coalescer_chk #(
  .LANES(LANES), .AW(AW), .LINE_BYTES(LINE_BYTES), .SECTOR_BYTES(SECTOR_BYTES)
) chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .txnValid(txnValid), .txnReady(txnReady), .txnAddr(txnAddr),
  .txnWide(txnWide), .txnMask(txnMask), .done(done)
);

// File: tb/coalescer_top_test.sv
module coalescer_top_test;
  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [31:0]   laneValid = '0;
  logic [1023:0] laneAddr = '0;
  logic          txnValid;
  logic          txnReady = 1'b0;
  logic [31:0]   txnAddr;
  logic          txnWide;
  logic [31:0]   txnMask;
  logic          done;
  logic [12:0]   bytesRequested, bytesTransferred;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  coalescer_top uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .laneValid(laneValid), .laneAddr(laneAddr), .txnValid(txnValid),
    .txnReady(txnReady), .txnAddr(txnAddr), .txnWide(txnWide),
    .txnMask(txnMask), .done(done), .bytesRequested(bytesRequested),
    .bytesTransferred(bytesTransferred)
  );

  logic [31:0] curValid;
  logic [31:0] curAddr [32];
  logic [31:0] expAddr [64];
  logic        expWide [64];
  logic [31:0] expMask [64];
  int          expCnt;
  int          expXfer;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench model: walk distinct lines upward, apply the sector-count rule
  function automatic void buildExpected();
    logic [24:0] prevLine = '0;
    bit          first = 1'b1;
    expCnt  = 0;
    expXfer = 0;
    for (int iter = 0; iter < 32; iter++) begin
      logic [24:0] line = '0;
      bit          got = 1'b0;
      logic [3:0]  sec = '0;
      logic [31:0] lm = '0;
      for (int i = 0; i < 32; i++)
        if (curValid[i] && (first || curAddr[i][31:7] > prevLine) && (!got || curAddr[i][31:7] < line)) begin
          line = curAddr[i][31:7];
          got  = 1'b1;
        end
      if (!got) break;
      first = 1'b0;
      prevLine = line;
      for (int i = 0; i < 32; i++)
        if (curValid[i] && curAddr[i][31:7] == line) begin
          lm[i] = 1'b1;
          sec[curAddr[i][6:5]] = 1'b1;
        end
      if ($countones(sec) >= 3) begin
        expAddr[expCnt] = {line, 7'd0};
        expWide[expCnt] = 1'b1;
        expMask[expCnt] = lm;
        expCnt++;
        expXfer += 128;
      end else begin
        for (int s = 0; s < 4; s++) begin
          if (sec[s]) begin
            logic [31:0] sm = '0;
            for (int i = 0; i < 32; i++)
              if (lm[i] && curAddr[i][6:5] == 2'(s)) sm[i] = 1'b1;
            expAddr[expCnt] = {line, 2'(s), 5'd0};
            expWide[expCnt] = 1'b0;
            expMask[expCnt] = sm;
            expCnt++;
            expXfer += 32;
          end
        end
      end
    end
  endfunction

  task automatic runReq(input string tag);
    int got = 0;
    int cycles = 0;
    bit prevHs = 1'b0;
    bit stallPrev = 1'b0;
    logic [31:0] sAddr = '0, sMask = '0, unionMask = '0;
    logic sWide = 1'b0;
    buildExpected();
    @(negedge clk);
    check(reqReady === 1'b1, {"R10 ready before ", tag}, reqReady, 1);
    reqValid  = 1'b1;
    laneValid = curValid;
    for (int i = 0; i < 32; i++) laneAddr[i*32 +: 32] = curAddr[i];
    @(negedge clk);
    reqValid = 1'b0;
    laneValid = $urandom;
    for (int i = 0; i < 32; i++) laneAddr[i*32 +: 32] = $urandom;
    while (cycles < 400) begin
      txnReady = ($urandom % 10) < 7;
      if (stallPrev)
        check(txnValid && txnAddr == sAddr && txnMask == sMask && txnWide == sWide,
              {"R9 hold ", tag}, {txnAddr, txnMask}, {sAddr, sMask});
      stallPrev = 1'b0;
      if (done) begin
        check(got == expCnt, {"R3 R6 count ", tag}, got, expCnt);
        check(unionMask == curValid, {"R6 union ", tag}, unionMask, curValid);
        check((expCnt == 0) ? (cycles == 0) : prevHs, {"R8 R10 done timing ", tag}, cycles, 0);
        check(bytesRequested == 13'($countones(curValid) * 4), {"R7 requested ", tag},
              bytesRequested, $countones(curValid) * 4);
        check(bytesTransferred == 13'(expXfer), {"R7 transferred ", tag}, bytesTransferred, expXfer);
        @(negedge clk);
        check(reqReady && !done, {"R10 ready after done ", tag}, reqReady, 1);
        return;
      end
      prevHs = 1'b0;
      if (txnValid) begin
        if (txnReady) begin
          if (got < expCnt)
            check(txnAddr == expAddr[got] && txnWide == expWide[got] && txnMask == expMask[got],
                  {"R2 R3 R5 R6 txn ", tag}, {txnAddr, txnMask}, {expAddr[got], expMask[got]});
          else
            check(1'b0, {"R6 extra txn ", tag}, got, expCnt);
          unionMask |= txnMask;
          got++;
          prevHs = 1'b1;
        end else begin
          stallPrev = 1'b1;
          sAddr = txnAddr; sMask = txnMask; sWide = txnWide;
        end
      end
      @(negedge clk);
      cycles++;
    end
    check(1'b0, {"R10 no done ", tag}, cycles, 0);
  endtask

  task automatic strided(input logic [31:0] base, input int stride);
    for (int i = 0; i < 32; i++) curAddr[i] = base + 32'(i * stride * 4);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady === 1'b1 && txnValid === 1'b0 && done === 1'b0, "R1 reset ctrl", {reqReady, txnValid, done}, 3'b100);
    check(bytesRequested == 0 && bytesTransferred == 0, "R1 reset counters", {bytesRequested, bytesTransferred}, 0);

    // R4 contiguous aligned
    curValid = '1; strided(32'h0000_1000, 1);
    runReq("R4 contiguous");
    check(expCnt == 1 && expWide[0] && expMask[0] == 32'hFFFF_FFFF, "R4 model", expCnt, 1);
    // stride equal to a 32-word row: one sector per lane
    curValid = '1; strided(32'h0002_0000, 32);
    runReq("R3 row stride");
    // stride 2: two full lines
    curValid = '1; strided(32'h0000_3000, 2);
    runReq("R3 stride2");
    // misaligned contiguous: straddles two lines
    curValid = '1; strided(32'h0000_4040, 1);
    runReq("R3 misaligned");
    // R8 empty
    curValid = '0; strided(32'h0000_5000, 1);
    runReq("R8 empty");
    // two sectors of one line: narrow pair; three sectors: wide
    curValid = 32'h0000_0003; strided(32'h0, 0);
    curAddr[0] = 32'h0000_6004; curAddr[1] = 32'h0000_6064;
    runReq("R3 two sectors");
    curValid = 32'h0000_0007;
    curAddr[2] = 32'h0000_6044;
    runReq("R3 three sectors");
    // R11 invalid lanes carry far-away addresses
    curValid = 32'h0000_00FF; strided(32'h0000_7000, 1);
    for (int i = 8; i < 32; i++) curAddr[i] = $urandom;
    runReq("R11 ignore invalid");
    // random: clustered windows, mixed validity
    for (int n = 0; n < 60; n++) begin
      logic [31:0] base = ($urandom % 32'h0100_0000) & ~32'h3;
      int mode = $urandom % 3;
      curValid = (($urandom % 4) == 0) ? '1 : $urandom;
      if (mode == 0) strided(base, $urandom % 40);
      else for (int i = 0; i < 32; i++) curAddr[i] = base + (($urandom % 1024) & ~32'h3);
      runReq("R5 random");
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule